// File: doc/BRIEF.md
# Sequential Shift-Add Multiply / Shift-Subtract Divide Unit

This block is an iterative 64-bit integer arithmetic engine. One partial register, one operand shift register and one shared adder/subtractor produce a product, a quotient or a remainder. The operation is chosen by a two-bit code. The operands are unsigned. A multiply takes the multiplier bits most significant first and does a shift-add step. A divide uses restoring shift-subtract. In both cases a normal cycle consumes one operand bit.

Some operands contain long runs of zero bits, so the unit has a fast path for them. When the next eight operand bits to be consumed are all zero, and more than eight iterations remain, the unit shifts eight positions in a single cycle and performs no arithmetic. For a divide, this fast path is also allowed only while the partial remainder is zero and the divisor is non-zero.

The surrounding pipeline raises `start` for one cycle with the code and both operands. It then waits for the single-cycle `done` pulse and reads `result`.

Top module: `mdu_seq`

## Requirements
- R1: Code 0 and code 3 both multiply, and `result` is the low 64 bits of `opa * opb`.
- R2: Code 1 divides, and `result` is the unsigned quotient `opa / opb`.
- R3: Code 2 computes the remainder, and `result` is the unsigned value `opa % opb`.
- R4: If `opb` is zero, code 1 returns all ones and code 2 returns `opa`, and no cycle of that operation takes the eight-bit fast path.
- R5: An operation that never skips ends `done` exactly 64 cycles after the cycle in which `start` is accepted. Each ordinary step consumes one operand bit and lowers the remaining count by one.
- R6: During a multiply, suppose the eight most significant not-yet-consumed multiplier (`opa`) bits are zero and more than eight steps remain. The unit then consumes those eight bits in one cycle, and the remaining count drops by eight.
- R7: During a divide, the eight-bit skip happens only under three conditions together: the partial remainder is zero, the next eight dividend bits are zero, and more than eight steps remain. The partial remainder of `opa` is the value of the dividend bits consumed so far, reduced modulo `opb`.
- R8: `busy` is high from the cycle after an accepted `start` until the cycle in which `done` rises. `done` is high for exactly one cycle.
- R9: A `start` raised while `busy` is high is ignored. The running operation completes with its own operands, and no second operation follows.
- R10: After reset, `busy` and `done` are low.
- R11: `result` holds its value from the `done` cycle until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a new operation; sampled only while idle |
| opc | input | 2 | Operation code: 0/3 multiply, 1 quotient, 2 remainder |
| opa | input | 64 | Multiplier or dividend |
| opb | input | 64 | Multiplicand or divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Product low half, quotient or remainder |

## Verification
Most internal faults show up at the ports as a change in timing, before any wrong value appears. A count that drops by the wrong amount, or a skip taken under the wrong condition, moves the `done` pulse away from the latency the bench predicts from the operand bits. That shift can be seen as soon as the operation ends, within at most 64 cycles.

A corrupted partial register or quotient shift register shows up as a wrong `result` in the `done` cycle. Skip cases are therefore mixed in on purpose: zero multipliers, small dividends, unit divisors and zero divisors. In these cases a premature or forbidden skip changes both the latency and the value.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

    // Operation select; code 3 is an alias for multiply
    typedef enum logic [1:0] {
        OPC_MUL     = 2'd0,
        OPC_QUO     = 2'd1,
        OPC_REM     = 2'd2,
        OPC_MUL_ALT = 2'd3
    } opc_e;

    // Datapath personality derived from the operation code
    typedef enum logic {
        MODE_MUL = 1'b0,
        MODE_DIV = 1'b1
    } mode_e;

    // Per-operation state kept for the duration of a computation
    typedef struct packed {
        opc_e  opc;
        mode_e mode;
    } op_ctx_t;

    function automatic mode_e mode_of(opc_e o);
        return (o == OPC_QUO || o == OPC_REM) ? MODE_DIV : MODE_MUL;
    endfunction

    function automatic logic selects_partial(opc_e o);
        return (o != OPC_QUO);
    endfunction

endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl #(
    parameter int XLEN = 64,
    parameter int SKIP = 8,
    parameter int CW   = $clog2(XLEN + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          skip_go,
    output logic          load,
    output logic          busy,
    output logic          done,
    output logic [CW-1:0] cnt
);

    localparam logic [CW-1:0] CNT_FULL = CW'(XLEN);
    localparam logic [CW-1:0] CNT_SKIP = CW'(SKIP);
    localparam logic [CW-1:0] CNT_ONE  = CW'(1);

    logic          busy_q;
    logic          done_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nxt;

    assign load    = start && !busy_q;
    assign cnt_nxt = cnt_q - (skip_go ? CNT_SKIP : CNT_ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (load) begin
                busy_q <= 1'b1;
                cnt_q  <= CNT_FULL;
            end else if (busy_q) begin
                cnt_q <= cnt_nxt;
                if (cnt_nxt == '0) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;
    assign cnt  = cnt_q;

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        busy_q |=> (!busy_q || cnt_q == $past(cnt_q) - CNT_ONE
                            || cnt_q == $past(cnt_q) - CNT_SKIP)); // R5

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R8

    AST_FALL_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> done_q); // R8

    AST_SKIP_KEEPS_TAIL: assert property (@(posedge clk) disable iff (rst)
        (busy_q && skip_go) |=> (busy_q && !done_q)); // R6

endmodule

// File: rtl/mdu_zero_scan.sv
module mdu_zero_scan
    import mdu_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int SKIP    = 8,
    parameter int CW      = $clog2(XLEN + 1),
    parameter bit SKIP_EN = 1'b1
) (
    input  logic            busy,
    input  mode_e           mode,
    input  logic [SKIP-1:0] window,
    input  logic            part_zero,
    input  logic            opnd_zero,
    input  logic [CW-1:0]   cnt,
    output logic            skip_go
);

    localparam logic [CW-1:0] CNT_SKIP = CW'(SKIP);

    logic window_clear;
    logic room_left;
    logic mode_allows;

    assign window_clear = (window == '0);
    assign room_left    = (cnt > CNT_SKIP);

    // Divide may only skip while nothing has accumulated and the divisor
    // can actually be subtracted; multiply may skip on any zero window.
    always_comb begin
        unique case (mode)
            MODE_DIV: mode_allows = part_zero && !opnd_zero;
            default:  mode_allows = 1'b1;
        endcase
    end

    assign skip_go = SKIP_EN && busy && window_clear && room_left && mode_allows;

endmodule

// File: rtl/mdu_datapath.sv
module mdu_datapath
    import mdu_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int SKIP = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            step,
    input  logic            skip_go,
    input  logic [1:0]      opc_in,
    input  logic [XLEN-1:0] opa_in,
    input  logic [XLEN-1:0] opb_in,
    output mode_e           mode,
    output logic [SKIP-1:0] window,
    output logic            part_zero,
    output logic            opnd_zero,
    output logic [XLEN-1:0] result
);

    localparam int AW = XLEN + 2;

    op_ctx_t         ctx_q;
    logic [XLEN-1:0] part_q;
    logic [XLEN-1:0] shreg_q;
    logic [XLEN-1:0] opnd_q;

    logic            in_bit;
    logic [AW-1:0]   base;
    logic [AW-1:0]   addend;
    logic [AW-1:0]   sum;
    logic            fits;
    logic [XLEN-1:0] part_step;
    logic [XLEN-1:0] shreg_step;
    logic [XLEN-1:0] part_skip;
    logic [XLEN-1:0] shreg_skip;

    assign in_bit = shreg_q[XLEN-1];

    // Single shared adder: adds the multiplicand or subtracts the divisor
    always_comb begin
        if (ctx_q.mode == MODE_DIV) begin
            base   = {1'b0, part_q, in_bit};
            addend = ~{2'b00, opnd_q};
        end else begin
            base   = {1'b0, part_q, 1'b0};
            addend = in_bit ? {2'b00, opnd_q} : '0;
        end
        sum  = base + addend + AW'(ctx_q.mode == MODE_DIV);
        fits = ~sum[AW-1];
    end

    always_comb begin
        if (ctx_q.mode == MODE_DIV) begin
            part_step  = fits ? sum[XLEN-1:0] : base[XLEN-1:0];
            shreg_step = {shreg_q[XLEN-2:0], fits};
            part_skip  = part_q;
        end else begin
            part_step  = sum[XLEN-1:0];
            shreg_step = {shreg_q[XLEN-2:0], 1'b0};
            part_skip  = part_q << SKIP;
        end
        shreg_skip = shreg_q << SKIP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q   <= '{opc: OPC_MUL, mode: MODE_MUL};
            part_q  <= '0;
            shreg_q <= '0;
            opnd_q  <= '0;
        end else if (load) begin
            ctx_q.opc  <= opc_e'(opc_in);
            ctx_q.mode <= mode_of(opc_e'(opc_in));
            part_q     <= '0;
            shreg_q    <= opa_in;
            opnd_q     <= opb_in;
        end else if (step) begin
            if (skip_go) begin
                part_q  <= part_skip;
                shreg_q <= shreg_skip;
            end else begin
                part_q  <= part_step;
                shreg_q <= shreg_step;
            end
        end
    end

    assign mode      = ctx_q.mode;
    assign window    = shreg_q[XLEN-1 -: SKIP];
    assign part_zero = (part_q == '0);
    assign opnd_zero = (opnd_q == '0);
    assign result    = selects_partial(ctx_q.opc) ? part_q : shreg_q;

    AST_DIV_SKIP_ZERO_REM: assert property (@(posedge clk) disable iff (rst)
        (step && skip_go && ctx_q.mode == MODE_DIV) |=> (part_q == '0)); // R7

    AST_OPERAND_FROZEN: assert property (@(posedge clk) disable iff (rst)
        step |=> $stable(opnd_q)); // R9

endmodule

// File: rtl/mdu_seq.sv
module mdu_seq
    import mdu_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int SKIP    = 8,
    parameter bit SKIP_EN = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [1:0]      opc,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] result
);

    localparam int CW = $clog2(XLEN + 1);

    logic            load;
    logic            skip_go;
    logic [CW-1:0]   cnt;
    mode_e           mode;
    logic [SKIP-1:0] window;
    logic            part_zero;
    logic            opnd_zero;

    mdu_ctrl #(.XLEN(XLEN), .SKIP(SKIP), .CW(CW)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .skip_go (skip_go),
        .load    (load),
        .busy    (busy),
        .done    (done),
        .cnt     (cnt)
    );

    mdu_zero_scan #(.XLEN(XLEN), .SKIP(SKIP), .CW(CW), .SKIP_EN(SKIP_EN)) u_scan (
        .busy      (busy),
        .mode      (mode),
        .window    (window),
        .part_zero (part_zero),
        .opnd_zero (opnd_zero),
        .cnt       (cnt),
        .skip_go   (skip_go)
    );

    mdu_datapath #(.XLEN(XLEN), .SKIP(SKIP)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .step      (busy),
        .skip_go   (skip_go),
        .opc_in    (opc),
        .opa_in    (opa),
        .opb_in    (opb),
        .mode      (mode),
        .window    (window),
        .part_zero (part_zero),
        .opnd_zero (opnd_zero),
        .result    (result)
    );

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(result)); // R11

    AST_DIV0_NO_SKIP: assert property (@(posedge clk) disable iff (rst)
        (busy && mode == MODE_DIV && opnd_zero) |-> !skip_go); // R4

endmodule

// File: tb/tb_mdu_seq.sv
module tb_mdu_seq;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [1:0]  opc;
    logic [63:0] opa;
    logic [63:0] opb;
    logic        busy;
    logic        done;
    logic [63:0] result;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    mdu_seq dut (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .opc    (opc),
        .opa    (opa),
        .opb    (opb),
        .busy   (busy),
        .done   (done),
        .result (result)
    );

    task automatic check(input bit ok, input string req, input longint unsigned act,
                         input longint unsigned exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic longint unsigned exp_result(input logic [1:0] op,
                                                   input longint unsigned a,
                                                   input longint unsigned b);
        case (op)
            2'd1:    return (b == 0) ? 64'hFFFF_FFFF_FFFF_FFFF : a / b;
            2'd2:    return (b == 0) ? a : a % b;
            default: return a * b;
        endcase
    endfunction

    function automatic string result_req(input logic [1:0] op, input longint unsigned b);
        if ((op == 2'd1 || op == 2'd2) && b == 0) return "R4";
        if (op == 2'd1) return "R2";
        if (op == 2'd2) return "R3";
        return "R1";
    endfunction

    // Steps predicted from the skip rules of R5, R6, R7 and R4
    function automatic int exp_lat(input logic [1:0] op, input longint unsigned a,
                                   input longint unsigned b);
        int  cnt = 64;
        int  k = 0;
        int  n = 0;
        bit  is_div = (op == 2'd1 || op == 2'd2);
        while (cnt > 0) begin
            longint unsigned win = (a << k) >> 56;
            bit rem_zero = 1'b1;
            if (is_div) begin
                if (b == 0) rem_zero = 1'b0;
                else if (k > 0) rem_zero = (((a >> (64 - k)) % b) == 0);
            end
            if (cnt > 8 && win == 0 && rem_zero) begin
                k += 8; cnt -= 8;
            end else begin
                k += 1; cnt -= 1;
            end
            n++;
        end
        return n;
    endfunction

    function automatic string lat_req(input logic [1:0] op, input int lat);
        if (lat == 64) return "R5";
        if (op == 2'd1 || op == 2'd2) return "R7";
        return "R6";
    endfunction

    // Issue one operation; optionally raise a stray start part-way through.
    task automatic run_op(input logic [1:0] op, input longint unsigned a,
                          input longint unsigned b, input int stray_at);
        longint unsigned want = exp_result(op, a, b);
        int want_lat = exp_lat(op, a, b);
        int lat = 0;
        bit hung = 1'b0;
        @(negedge clk);
        start = 1'b1; opc = op; opa = a; opb = b;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R8", busy, 1);
        while (!done) begin
            if (lat == stray_at) begin
                start = 1'b1; opc = 2'd1; opa = ~a; opb = 64'd3;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
            if (lat > 200) begin hung = 1'b1; break; end
        end
        start = 1'b0;
        if (hung) begin
            check(1'b0, "R8 watchdog", lat, want_lat);
            return;
        end
        check(result == want, result_req(op, b), result, want);
        check(lat == want_lat, lat_req(op, want_lat), lat, want_lat);
        check(busy == 1'b0, "R8", busy, 0);
        @(negedge clk);
        check(done == 1'b0, "R8", done, 0);
        if (stray_at >= 0) check(busy == 1'b0, "R9", busy, 0);
        repeat (2) @(negedge clk);
        check(result == want, "R11", result, want);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; opc = '0; opa = '0; opb = '0;
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R10", busy, 0);
        check(done == 1'b0, "R10", done, 0);
        rst = 1'b0;

        // Directed corners
        run_op(2'd0, 64'd3, 64'd5, -1);                                  // R1
        run_op(2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, -1); // R1 R5
        run_op(2'd3, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9, -1);        // R1 alias
        run_op(2'd0, 64'd0, 64'd77, -1);                                 // R6: 15 steps
        run_op(2'd0, 64'h0000_0001_0000_0000, 64'd9, -1);                // R6
        run_op(2'd1, 64'd100, 64'd7, -1);                                // R2
        run_op(2'd2, 64'd100, 64'd7, -1);                                // R3
        run_op(2'd1, 64'd5, 64'd1000, -1);                               // R2
        run_op(2'd1, 64'd0, 64'd5, -1);                                  // R7
        run_op(2'd2, 64'hFF00_0000_0000_0001, 64'd1, -1);                // R7
        run_op(2'd1, 64'hDEAD_BEEF_0000_0000, 64'd0, -1);                // R4
        run_op(2'd2, 64'h0000_0000_0000_00A5, 64'd0, -1);                // R4
        run_op(2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 10);                // R9
        run_op(2'd2, 64'h8000_0000_0000_0000, 64'd6, 40);                // R9

        // Constrained random mix with zero runs
        void'($urandom(32'd20240406));
        for (int i = 0; i < 160; i++) begin
            longint unsigned a = {$urandom(), $urandom()};
            longint unsigned b = {$urandom(), $urandom()};
            int sa = $urandom_range(0, 63);
            int sb = $urandom_range(0, 63);
            logic [1:0] op = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 1) == 1) a = a >> sa;
            if ($urandom_range(0, 1) == 1) b = b >> sb;
            if ($urandom_range(0, 15) == 0) b = 0;
            run_op(op, a, b, -1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule